// File: doc/BRIEF.md
# Parallel Flash Completion Poller

This block sits on the host side of an asynchronous parallel flash bus. After software or another controller has issued a program or erase command to the flash, a single start pulse hands the poller the operation kind, the target address and the word that was written. The poller then runs back-to-back read cycles on that address until the flash reports that its internal operation has ended. It then raises a one-cycle done pulse together with a pass or timeout verdict.

Two detection schemes are offered and chosen per run. In bit-7 polling, a running program returns the inverse of the written bit 7 and a running erase returns 0 there. Once that bit settles to its final value, one more read fetches the whole word and checks it. In bit-6 toggle detection, bit 6 flips on every read while the flash is busy. Two equal values in a row mean the flash is idle, and the read that showed this is checked as a whole word. Reading starts in the cycle after start with no initial wait. The strobe width and the maximum number of polling reads are run-time inputs.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high (inactive), and busy, done, pass and timeout are all low.
- R2: A start request is taken only while busy is low. Taking it latches the operation kind, detection mode, address, data, strobe width and read limit, and sets busy. A start while busy has no effect on the run in progress or on the address driven.
- R3: Each read cycle drives chip enable and output enable low together for L clocks and then high for at least one clock. L is the strobe-width input, with 0 treated as 1. The flash data is sampled on the last of the L clocks. Write enable stays high at all times, and the address output equals the latched address while busy.
- R4: In bit-7 polling of a program (op-kind input 0), a read counts as a match when data bit 7 equals bit 7 of the latched data.
- R5: In bit-7 polling of an erase (op-kind input 1), a read counts as a match when data bit 7 is 1.
- R6: After a bit-7 match, exactly one more read is made. Pass is set when that whole word equals the expected word: the latched data for a program, all ones for an erase.
- R7: In toggle mode (mode input 1), the run ends when a read shows the same bit 6 as the read just before it. Pass is set when that read's whole word equals the expected word of R6.
- R8: If the number of polling reads reaches the limit input (0 treated as 1) without the end condition of R4, R5 or R7, the run ends with timeout high and pass low. The confirming read of R6 does not count toward the limit.
- R9: Done is a one-cycle pulse in the cycle after the final sample, and busy is low in that same cycle. Pass and timeout keep their value until the next start is taken, and are cleared when it is.
- R10: The first read strobe is driven in the cycle right after the start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| op_erase_i | input | 1 | 1 = erase was issued, 0 = program |
| mode_toggle_i | input | 1 | 1 = bit-6 toggle detection, 0 = bit-7 polling |
| addr_i | input | ADDR_W | Address to poll |
| data_i | input | DATA_W | Word that was programmed |
| strobe_len_i | input | LEN_W | Clocks per read strobe (0 means 1) |
| poll_limit_i | input | LIM_W | Maximum polling reads (0 means 1) |
| fl_addr_o | output | ADDR_W | Flash address |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_we_n_o | output | 1 | Flash write enable, active low, held high |
| fl_data_i | input | DATA_W | Flash read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| pass_o | output | 1 | Final word matched expectation |
| timeout_o | output | 1 | Read limit reached without completion |

## Verification
A wrong strobe counter or state shows up in the strobe pins in the very next cycle. The strobes then stretch, shorten or lose the gap cycle, so the bench compares them against its reference model every clock. A wrong latch of the operation kind or of the toggle history does not show at once. It appears at the end of the run as a done pulse on the wrong read, a missing confirming read, or a wrong pass or timeout verdict. The flash model in the bench is built so that each of these cases moves the done pulse by at least one full read period.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

    // bit positions the flash uses to report its internal state
    localparam int POLL_BIT   = 7;
    localparam int TOGGLE_BIT = 6;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_READ = 2'd1,
        PS_GAP  = 2'd2
    } fpoll_state_e;

endpackage

// File: rtl/fpoll_strobe.sv
// Counts the clocks of one read strobe and flags the sampling clock.
module fpoll_strobe #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [LEN_W-1:0] len_i,     // already forced to at least 1
    output logic             last_o
);
    logic [LEN_W-1:0] cnt_d, cnt_q;
    logic [LEN_W-1:0] len_m1;

    always_comb begin
        len_m1 = len_i - 1'b1;
        last_o = run_i && (cnt_q == len_m1);
        if (!run_i || last_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fpoll_budget.sv
// Counts polling reads and flags the read that reaches the limit.
module fpoll_budget #(
    parameter int LIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic [LIM_W-1:0] lim_i,     // already forced to at least 1
    output logic             at_limit_o
);
    logic [LIM_W-1:0] cnt_d, cnt_q;
    logic [LIM_W:0]   next_cnt;

    always_comb begin
        next_cnt   = {1'b0, cnt_q} + 1'b1;
        at_limit_o = (next_cnt >= {1'b0, lim_i});
        if (clr_i) begin
            cnt_d = '0;
        end else if (step_i && !at_limit_o) begin
            cnt_d = next_cnt[LIM_W-1:0];
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/fpoll_judge.sv
// Evaluates one sampled flash word against the status-bit rules.
module fpoll_judge
    import fpoll_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              erase_i,
    input  logic [DATA_W-1:0] loaded_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              have_prev_i,
    input  logic              prev_t_i,
    output logic              poll_hit_o,
    output logic              settled_o,
    output logic              word_ok_o
);
    logic [DATA_W-1:0] expect_w;

    always_comb begin
        expect_w   = erase_i ? {DATA_W{1'b1}} : loaded_i;
        word_ok_o  = (word_i == expect_w);
        // erase drives 0 until done; program drives the inverse until done
        poll_hit_o = erase_i ? word_i[POLL_BIT]
                             : (word_i[POLL_BIT] == loaded_i[POLL_BIT]);
        settled_o  = have_prev_i && (word_i[TOGGLE_BIT] == prev_t_i);
    end
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import fpoll_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int LEN_W  = 4,
    parameter int LIM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              op_erase_i,
    input  logic              mode_toggle_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [LEN_W-1:0]  strobe_len_i,
    input  logic [LIM_W-1:0]  poll_limit_i,
    output logic [ADDR_W-1:0] fl_addr_o,
    output logic              fl_ce_n_o,
    output logic              fl_oe_n_o,
    output logic              fl_we_n_o,
    input  logic [DATA_W-1:0] fl_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              timeout_o
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
    localparam logic [LIM_W-1:0] LIM_ONE = LIM_W'(1);

    typedef struct packed {
        fpoll_state_e      st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              erase;
        logic              toggle;
        logic [LEN_W-1:0]  len;
        logic [LIM_W-1:0]  lim;
        logic              confirm;   // next read is the full-word check
        logic              have_prev;
        logic              prev_t;
        logic              done;
        logic              pass;
        logic              tmo;
    } fpoll_regs_t;

    fpoll_regs_t r_d, r_q;

    logic strobe_last;
    logic sample;
    logic take_start;
    logic at_limit;
    logic poll_hit, settled, word_ok;

    assign take_start = (r_q.st == PS_IDLE) && start_i;
    assign sample     = (r_q.st == PS_READ) && strobe_last;

    fpoll_strobe #(.LEN_W(LEN_W)) u_strobe (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (r_q.st == PS_READ),
        .len_i  (r_q.len),
        .last_o (strobe_last)
    );

    fpoll_budget #(.LIM_W(LIM_W)) u_budget (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (take_start),
        .step_i     (sample && !r_q.confirm),
        .lim_i      (r_q.lim),
        .at_limit_o (at_limit)
    );

    fpoll_judge #(.DATA_W(DATA_W)) u_judge (
        .erase_i     (r_q.erase),
        .loaded_i    (r_q.data),
        .word_i      (fl_data_i),
        .have_prev_i (r_q.have_prev),
        .prev_t_i    (r_q.prev_t),
        .poll_hit_o  (poll_hit),
        .settled_o   (settled),
        .word_ok_o   (word_ok)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            PS_IDLE: begin
                if (start_i) begin
                    r_d.st        = PS_READ;
                    r_d.addr      = addr_i;
                    r_d.data      = data_i;
                    r_d.erase     = op_erase_i;
                    r_d.toggle    = mode_toggle_i;
                    r_d.len       = (strobe_len_i == '0) ? LEN_ONE : strobe_len_i;
                    r_d.lim       = (poll_limit_i == '0) ? LIM_ONE : poll_limit_i;
                    r_d.confirm   = 1'b0;
                    r_d.have_prev = 1'b0;
                    r_d.prev_t    = 1'b0;
                    r_d.pass      = 1'b0;
                    r_d.tmo       = 1'b0;
                end
            end
            PS_READ: begin
                if (sample) begin
                    r_d.st = PS_GAP;
                    if (r_q.confirm) begin
                        r_d.st   = PS_IDLE;
                        r_d.done = 1'b1;
                        r_d.pass = word_ok;
                    end else if (!r_q.toggle) begin
                        if (poll_hit) begin
                            r_d.confirm = 1'b1;
                        end else if (at_limit) begin
                            r_d.st   = PS_IDLE;
                            r_d.done = 1'b1;
                            r_d.tmo  = 1'b1;
                        end
                    end else begin
                        if (settled) begin
                            r_d.st   = PS_IDLE;
                            r_d.done = 1'b1;
                            r_d.pass = word_ok;
                        end else begin
                            r_d.have_prev = 1'b1;
                            r_d.prev_t    = fl_data_i[TOGGLE_BIT];
                            if (at_limit) begin
                                r_d.st   = PS_IDLE;
                                r_d.done = 1'b1;
                                r_d.tmo  = 1'b1;
                            end
                        end
                    end
                end
            end
            PS_GAP: begin
                r_d.st = PS_READ;
            end
            default: begin
                r_d.st = PS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: PS_IDLE, addr: '0, data: '0, erase: 1'b0, toggle: 1'b0,
                     len: LEN_ONE, lim: LIM_ONE, confirm: 1'b0, have_prev: 1'b0,
                     prev_t: 1'b0, done: 1'b0, pass: 1'b0, tmo: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign fl_addr_o = r_q.addr;
    assign fl_ce_n_o = (r_q.st != PS_READ);
    assign fl_oe_n_o = (r_q.st != PS_READ);
    assign fl_we_n_o = 1'b1;
    assign busy_o    = (r_q.st != PS_IDLE);
    assign done_o    = r_q.done;
    assign pass_o    = r_q.pass;
    assign timeout_o = r_q.tmo;
endmodule

// File: rtl/fpoll_checker.sv
module fpoll_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] fl_addr_o,
    input logic              fl_ce_n_o,
    input logic              fl_oe_n_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              pass_o,
    input logic              timeout_o
);
    AST_CE_OE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        fl_ce_n_o == fl_oe_n_o);                                            // R3
    AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_ce_n_o |-> busy_o);                                             // R3
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(fl_addr_o));                  // R3
    AST_FIRST_READ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> !fl_ce_n_o);                               // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                                // R9
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(pass_o) && $stable(timeout_o))); // R9
    AST_TIMEOUT_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> !pass_o);                                             // R8
endmodule

bind flash_done_poller fpoll_checker #(.ADDR_W(ADDR_W)) u_fpoll_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .fl_addr_o (fl_addr_o),
    .fl_ce_n_o (fl_ce_n_o),
    .fl_oe_n_o (fl_oe_n_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .pass_o    (pass_o),
    .timeout_o (timeout_o)
);

// File: tb/flash_done_poller_bench.sv
module flash_done_poller_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int LW = 4;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          op_erase_i = 1'b0;
    logic          mode_toggle_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [DW-1:0] data_i = '0;
    logic [LW-1:0] strobe_len_i = '0;
    logic [CW-1:0] poll_limit_i = '0;
    logic [AW-1:0] fl_addr_o;
    logic          fl_ce_n_o, fl_oe_n_o, fl_we_n_o;
    logic [DW-1:0] fl_data_i;
    logic          busy_o, done_o, pass_o, timeout_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_done_poller #(.ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .LIM_W(CW)) u_flash_done_poller (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .mode_toggle_i(mode_toggle_i), .addr_i(addr_i), .data_i(data_i),
        .strobe_len_i(strobe_len_i), .poll_limit_i(poll_limit_i),
        .fl_addr_o(fl_addr_o), .fl_ce_n_o(fl_ce_n_o), .fl_oe_n_o(fl_oe_n_o),
        .fl_we_n_o(fl_we_n_o), .fl_data_i(fl_data_i), .busy_o(busy_o),
        .done_o(done_o), .pass_o(pass_o), .timeout_o(timeout_o)
    );

    // ---------------- flash behaviour model ----------------
    int          f_reads = 0;      // completed read cycles
    int          f_busy_reads = 0; // reads that still show "busy"
    logic        f_erase = 1'b0;
    logic [15:0] f_loaded = '0;
    logic [15:0] f_final = '0;

    always @(posedge fl_oe_n_o) f_reads++;

    always_comb begin
        if (f_reads < f_busy_reads) begin
            fl_data_i    = 16'h1234;
            fl_data_i[7] = f_erase ? 1'b0 : ~f_loaded[7];
            fl_data_i[6] = f_reads[0];
        end else begin
            fl_data_i = f_final;
        end
    end

    // ---------------- reference model ----------------
    bit          m_busy, m_gap, m_done, m_pass, m_tmo, m_er, m_tg, m_conf, m_hp, m_p6;
    int          m_cyc, m_len, m_lim, m_reads;
    logic [19:0] m_addr;
    logic [15:0] m_d;

    task automatic m_finish(input bit p, input bit t);
        m_busy = 0; m_done = 1; m_pass = p; m_tmo = t;
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy = 0; m_gap = 0; m_done = 0; m_pass = 0; m_tmo = 0;
            m_conf = 0; m_hp = 0; m_p6 = 0; m_cyc = 0; m_reads = 0;
            m_addr = '0; m_d = '0; m_er = 0; m_tg = 0; m_len = 1; m_lim = 1;
        end else begin
            logic [15:0] w, ex;
            bit hit;
            m_done = 0;
            if (!m_busy) begin
                if (start_i) begin
                    m_busy = 1; m_gap = 0; m_cyc = 0; m_reads = 0;
                    m_conf = 0; m_hp = 0; m_pass = 0; m_tmo = 0;
                    m_addr = addr_i; m_d = data_i; m_er = op_erase_i; m_tg = mode_toggle_i;
                    m_len = (strobe_len_i == 0) ? 1 : int'(strobe_len_i);
                    m_lim = (poll_limit_i == 0) ? 1 : int'(poll_limit_i);
                end
            end else if (m_gap) begin
                m_gap = 0;
            end else begin
                m_cyc++;
                if (m_cyc == m_len) begin
                    m_cyc = 0;
                    w  = fl_data_i;
                    ex = m_er ? 16'hFFFF : m_d;
                    if (m_conf) begin
                        m_finish(w == ex, 0);
                    end else begin
                        m_reads++;
                        if (!m_tg) begin
                            hit = m_er ? w[7] : (w[7] == m_d[7]);
                            if (hit) begin m_conf = 1; m_gap = 1; end
                            else if (m_reads >= m_lim) m_finish(0, 1);
                            else m_gap = 1;
                        end else if (m_hp && (w[6] == m_p6)) begin
                            m_finish(w == ex, 0);
                        end else begin
                            m_p6 = w[6]; m_hp = 1;
                            if (m_reads >= m_lim) m_finish(0, 1);
                            else m_gap = 1;
                        end
                    end
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (rst_n && !finished) begin
            check("R3 chip enable",  32'(fl_ce_n_o), 32'(!(m_busy && !m_gap)));
            check("R3 output enable", 32'(fl_oe_n_o), 32'(!(m_busy && !m_gap)));
            check("R3 write enable", 32'(fl_we_n_o), 32'd1);
            check("R2 busy",         32'(busy_o),    32'(m_busy));
            check("R9 done",         32'(done_o),    32'(m_done));
            check("R6 pass",         32'(pass_o),    32'(m_pass));
            check("R8 timeout",      32'(timeout_o), 32'(m_tmo));
            if (m_busy) check("R3 address", 32'(fl_addr_o), 32'(m_addr));
        end
    end

    task automatic summary();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        fails++; checks++;
        $display("FAIL watchdog run hung actual=%0d expected<150000", cycles);
        summary();
    end

    // one polling run with scenario-level expectations
    task automatic run(input string tag, input bit er, input bit tg, input logic [19:0] a,
                       input logic [15:0] d, input int len, input int lim,
                       input int busy_reads, input logic [15:0] fin,
                       input bit exp_pass, input bit exp_tmo, input int inject_at);
        int waited;
        bit seen;
        @(negedge clk);
        f_reads = 0; f_busy_reads = busy_reads; f_erase = er; f_loaded = d; f_final = fin;
        op_erase_i = er; mode_toggle_i = tg; addr_i = a; data_i = d;
        strobe_len_i = LW'(len); poll_limit_i = CW'(lim);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " R10 first strobe"}, 32'(fl_ce_n_o), 32'd0);
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (i == inject_at) begin
                addr_i = ~a; op_erase_i = ~er; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (done_o) seen = 1;
            else @(negedge clk);
        end
        start_i = 1'b0;
        check({tag, " R9 done seen"}, 32'(seen), 32'd1);
        check({tag, " R9 busy low at done"}, 32'(busy_o), 32'd0);
        check({tag, " R2 address kept"}, 32'(fl_addr_o), 32'(a));
        check({tag, " verdict pass"}, 32'(pass_o), 32'(exp_pass));
        check({tag, " R8 verdict timeout"}, 32'(timeout_o), 32'(exp_tmo));
        @(negedge clk);
        check({tag, " R9 done one cycle"}, 32'(done_o), 32'd0);
        check({tag, " R9 pass held"}, 32'(pass_o), 32'(exp_pass));
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ce idle", 32'(fl_ce_n_o), 32'd1);
        check("R1 oe idle", 32'(fl_oe_n_o), 32'd1);
        check("R1 we idle", 32'(fl_we_n_o), 32'd1);
        check("R1 flags", 32'({busy_o, done_o, pass_o, timeout_o}), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R4 R6: program, bit-7 polling, good word (loaded bit 7 = 1)
        run("R4 R6 prog poll ok",   0, 0, 20'h1A5A5, 16'h12B4, 2, 20, 3, 16'h12B4, 1, 0, -1);
        // R4: loaded bit 7 = 0, busy reads show 1
        run("R4 prog bit7 zero",    0, 0, 20'h00010, 16'h0042, 1, 20, 4, 16'h0042, 1, 0, -1);
        // R6: bit 7 matches but other bits differ -> fail
        run("R6 prog poll bad",     0, 0, 20'h00F00, 16'h5A3C, 2, 20, 2, 16'h5A3D, 0, 0, -1);
        // R5: erase bit-7 polling
        run("R5 erase poll ok",     1, 0, 20'h40000, 16'h0000, 1, 20, 2, 16'hFFFF, 1, 0, -1);
        run("R5 R6 erase poll bad", 1, 0, 20'h40001, 16'h0000, 3, 20, 3, 16'hFF7F ^ 16'h0080 ^ 16'h0100, 0, 0, -1);
        // R7: toggle mode
        run("R7 prog toggle ok",    0, 1, 20'h00333, 16'h0F0F, 3, 20, 4, 16'h0F0F, 1, 0, -1);
        run("R7 erase toggle bad",  1, 1, 20'h00444, 16'h0000, 2, 20, 5, 16'hFFFE, 0, 0, -1);
        run("R7 toggle idle now",   0, 1, 20'h00555, 16'hBEEF, 1, 20, 0, 16'hBEEF, 1, 0, -1);
        // R8: timeouts
        run("R8 poll timeout",      0, 0, 20'h00666, 16'h00FF, 2, 5, 100, 16'h00FF, 0, 1, -1);
        run("R8 toggle lim zero",   0, 1, 20'h00777, 16'h00FF, 1, 0, 100, 16'h00FF, 0, 1, -1);
        // R8: limit reached exactly on the matching read still confirms
        run("R8 match at limit",    0, 0, 20'h00888, 16'h0080, 1, 3, 2, 16'h0080, 1, 0, -1);
        // R3: strobe width 0 acts as 1
        run("R3 zero width",        1, 0, 20'h00999, 16'h0000, 0, 20, 3, 16'hFFFF, 1, 0, -1);
        // R2: start while busy ignored
        run("R2 start while busy",  0, 0, 20'h0ABCD, 16'h1357, 3, 20, 6, 16'h1357, 1, 0, 4);
        summary();
    end
endmodule